// File: doc/BRIEF.md
# Shared Byte Buffer with Watermark Alerts

This block is a single 64-entry, byte-wide first-in first-out store. It sits between a host register port and an internal data engine. One storage array and one pair of pointers serve both directions: the host can fill the buffer for the engine to consume, or the engine can fill it for the host to drain. Either side may push or pop in any cycle. When both sides ask for the same kind of access in one cycle, the host wins and the engine's request is dropped.

The block reports how many bytes it holds. It keeps a programmable 6-bit watermark and derives two alert levels from it. The low alert tells a producer that the buffer is nearly drained. The high alert tells a consumer that free space is nearly used up, so it is measured against the space that remains and not against the fill level. A write to a full buffer is rejected and sets a sticky overflow flag. A flush input empties the buffer in one clock.

Top module: `shared_fifo_wm`

## Requirements
- R1: After reset the fill count is 0, the watermark is 8, the overflow flag is 0, the read data register is 00h, the low alert is 1 and the high alert is 0.
- R2: Bytes come out in the order they were accepted. A pop loads the oldest byte into `rd_data`, where it is visible from the clock edge that performs the pop. `rd_data` holds its value while no read is requested.
- R3: `fill_level` is a 7-bit count from 0 to 64. It rises by one for each accepted write and falls by one for each accepted read.
- R4: `alert_high` is 1 exactly when (64 − `fill_level`) ≤ watermark.
- R5: `alert_low` is 1 exactly when `fill_level` ≤ watermark.
- R6: A cycle with `wm_we` high loads `wm_wdata` into the 6-bit watermark, and `wm_level` shows it from the next cycle on.
- R7: A write while the count is 64 is discarded and leaves the stored data and the count unchanged. It sets `overflow`, which stays at 1 until a flush. This holds even if a read is accepted in the same cycle.
- R8: A read while the count is 0 loads 00h into `rd_data` and leaves the count at 0.
- R9: A flush sets the count to 0, resets both pointers and clears `overflow` in one clock. It takes priority over any read or write in the same cycle, and it leaves `rd_data` and the watermark unchanged.
- R10: If a write and a read are both accepted in one cycle while the buffer is neither empty nor full, the count stays the same and the written byte is queued behind the remaining ones.
- R11: If host and engine both request a write in one cycle, only the host byte is stored. If both request a read, only one byte is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer and clear overflow |
| host_wr | input | 1 | Host push request |
| host_rd | input | 1 | Host pop request |
| host_wdata | input | 8 | Host push data |
| eng_wr | input | 1 | Engine push request |
| eng_rd | input | 1 | Engine pop request |
| eng_wdata | input | 8 | Engine push data |
| wm_we | input | 1 | Watermark load strobe |
| wm_wdata | input | 6 | New watermark value |
| rd_data | output | 8 | Byte from the most recent read |
| fill_level | output | 7 | Number of stored bytes, 0 to 64 |
| wm_level | output | 6 | Current watermark |
| alert_high | output | 1 | Free space at or below watermark |
| alert_low | output | 1 | Fill level at or below watermark |
| overflow | output | 1 | Sticky write-while-full flag |

## Verification
The hardest case to reach from the ports is a full buffer that receives a read and a write in the same cycle. The read must succeed, the write must be rejected and still raise the overflow flag, and the count must drop to 63. The stimulus gets there in two ways. A directed phase fills the buffer past capacity from the engine side and then issues the combined access. A long random phase, with pushes weighted above pops, keeps the level near the top for many cycles. That random phase also moves the watermark between 0 and 63, so both alert comparisons are exercised at their endpoints.

// File: rtl/fwm_pkg.sv
package fwm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

  // free space at or below watermark
  function automatic logic space_alert(input int depth, input int level, input int wm);
    return (depth - level) <= wm;
  endfunction

  // fill level at or below watermark
  function automatic logic drain_alert(input int level, input int wm);
    return level <= wm;
  endfunction

endpackage

// File: rtl/fwm_arbiter.sv
module fwm_arbiter #(
  parameter int WIDTH = 8
) (
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             eng_wr,
  input  logic             eng_rd,
  input  logic [WIDTH-1:0] eng_wdata,
  output logic             wr_req,
  output logic             rd_req,
  output logic [WIDTH-1:0] wr_data
);
  // host has fixed priority for writes; reads merge to a single pop
  assign wr_req  = host_wr | eng_wr;
  assign rd_req  = host_rd | eng_rd;
  assign wr_data = host_wr ? host_wdata : eng_wdata;
endmodule

// File: rtl/fwm_ptrs.sv
module fwm_ptrs
  import fwm_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          do_wr,
  output logic          do_rd,
  output logic          rd_starved,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  logic     wr_blocked;
  fifo_op_e op;

  assign full       = (count == CW'(DEPTH));
  assign empty      = (count == '0);
  assign do_wr      = wr_req & ~full & ~flush;
  assign do_rd      = rd_req & ~empty & ~flush;
  assign wr_blocked = wr_req & full & ~flush;
  assign rd_starved = rd_req & empty & ~flush;
  assign op         = fifo_op_e'({do_rd, do_wr});

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_wr) wr_ptr <= bump(wr_ptr);
      if (do_rd) rd_ptr <= bump(rd_ptr);
      unique case (op)
        OP_PUSH: count <= count + 1'b1;
        OP_POP:  count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_blocked) ovf <= 1'b1;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R3
  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && !rd_req) |=> $stable(count)); // R7
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked || (ovf && !flush)) |=> ovf); // R7
  AST_EMPTY_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_starved && !wr_req) |=> count == '0); // R8
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && !ovf && wr_ptr == rd_ptr)); // R9
  AST_BALANCED_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && do_rd) |=> $stable(count)); // R10
endmodule

// File: rtl/fwm_store.sv
module fwm_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_wr,
  input  logic             do_rd,
  input  logic             rd_starved,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (do_rd)      rd_data <= mem[rd_ptr];
    else if (rd_starved) rd_data <= '0;
  end

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_starved |=> rd_data == '0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_rd && !rd_starved) |=> $stable(rd_data)); // R2
endmodule

// File: rtl/fwm_watermark.sv
module fwm_watermark
  import fwm_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int WM_RESET = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wm_we,
  input  logic [AW-1:0] wm_wdata,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] wm,
  output logic          alert_high,
  output logic          alert_low
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wm <= AW'(WM_RESET);
    else if (wm_we) wm <= wm_wdata;
  end

  assign alert_high = space_alert(DEPTH, int'(count), int'(wm));
  assign alert_low  = drain_alert(int'(count), int'(wm));

  AST_WM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wm_we |=> wm == $past(wm_wdata)); // R6
  AST_WM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wm_we |=> $stable(wm)); // R6
endmodule

// File: rtl/shared_fifo_wm.sv
module shared_fifo_wm #(
  parameter int DEPTH    = 64,
  parameter int WIDTH    = 8,
  parameter int WM_RESET = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             eng_wr,
  input  logic             eng_rd,
  input  logic [WIDTH-1:0] eng_wdata,
  input  logic             wm_we,
  input  logic [AW-1:0]    wm_wdata,
  output logic [WIDTH-1:0] rd_data,
  output logic [CW-1:0]    fill_level,
  output logic [AW-1:0]    wm_level,
  output logic             alert_high,
  output logic             alert_low,
  output logic             overflow
);
  logic             wr_req, rd_req, do_wr, do_rd, rd_starved, full, empty;
  logic [WIDTH-1:0] wr_data;
  logic [AW-1:0]    wr_ptr, rd_ptr;

  fwm_arbiter #(.WIDTH(WIDTH)) u_arb (
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_wdata(eng_wdata),
    .wr_req(wr_req), .rd_req(rd_req), .wr_data(wr_data)
  );

  fwm_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_req(wr_req), .rd_req(rd_req),
    .do_wr(do_wr), .do_rd(do_rd), .rd_starved(rd_starved),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(fill_level),
    .full(full), .empty(empty), .ovf(overflow)
  );

  fwm_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .do_wr(do_wr), .do_rd(do_rd),
    .rd_starved(rd_starved), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  fwm_watermark #(.DEPTH(DEPTH), .WM_RESET(WM_RESET)) u_wm (
    .clk(clk), .rst_n(rst_n), .wm_we(wm_we), .wm_wdata(wm_wdata),
    .count(fill_level), .wm(wm_level),
    .alert_high(alert_high), .alert_low(alert_low)
  );

  AST_LOW_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> alert_low); // R5
  AST_HIGH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> alert_high); // R4
  AST_HOST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && eng_wr && !full && !flush) |=> fill_level == $past(fill_level) + 1'b1 - CW'($past(do_rd))); // R11
endmodule

// File: tb/test_shared_fifo_wm.sv
module test_shared_fifo_wm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 0, host_wr = 0, host_rd = 0, eng_wr = 0, eng_rd = 0, wm_we = 0;
  logic [7:0] host_wdata = 0, eng_wdata = 0;
  logic [5:0] wm_wdata = 0;
  logic [7:0] rd_data;
  logic [6:0] fill_level;
  logic [5:0] wm_level;
  logic       alert_high, alert_low, overflow;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] q[$];
  int m_wm = 8;
  bit m_ovf = 0;
  int m_rd = 0;

  always #5ns clk = ~clk;

  shared_fifo_wm i_shared_fifo_wm (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .eng_wr(eng_wr), .eng_rd(eng_rd), .eng_wdata(eng_wdata),
    .wm_we(wm_we), .wm_wdata(wm_wdata),
    .rd_data(rd_data), .fill_level(fill_level), .wm_level(wm_level),
    .alert_high(alert_high), .alert_low(alert_low), .overflow(overflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 fill_level", int'(fill_level), q.size());
    chk("R4 alert_high", int'(alert_high), int'((64 - q.size()) <= m_wm));
    chk("R5 alert_low", int'(alert_low), int'(q.size() <= m_wm));
    chk("R6 wm_level", int'(wm_level), m_wm);
    chk("R7 overflow", int'(overflow), int'(m_ovf));
    chk("R2 rd_data", int'(rd_data), m_rd);
  endtask

  // one clock: drive, model the edge, compare just after it
  task automatic cyc(input bit hw, input bit hr, input int hd, input bit ew, input bit er,
                     input int ed, input bit fl, input bit we, input int wd);
    bit full0, empty0;
    host_wr = hw; host_rd = hr; host_wdata = 8'(hd);
    eng_wr = ew; eng_rd = er; eng_wdata = 8'(ed);
    flush = fl; wm_we = we; wm_wdata = 6'(wd);
    @(posedge clk);
    if (we) m_wm = wd & 63;
    if (fl) begin
      q.delete();
      m_ovf = 0;
    end else begin
      full0 = (q.size() == 64);
      empty0 = (q.size() == 0);
      if (hr || er) m_rd = empty0 ? 0 : int'(q.pop_front());
      if (hw || ew) begin
        if (full0) m_ovf = 1;
        else q.push_back(hw ? 8'(hd) : 8'(ed));
      end
    end
    #1ns;
    compare_all();
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0,0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;
    // R1 reset state
    chk("R1 fill", int'(fill_level), 0);
    chk("R1 wm", int'(wm_level), 8);
    chk("R1 ovf", int'(overflow), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 low", int'(alert_low), 1);
    chk("R1 high", int'(alert_high), 0);

    // R2 order through host side
    for (int i = 0; i < 10; i++) cyc(1,0,i*3+1,0,0,0,0,0,0);
    for (int i = 0; i < 10; i++) begin
      cyc(0,1,0,0,0,0,0,0,0);
      chk("R2 order", int'(rd_data), i*3+1);
    end
    idle();

    // R7 engine overfills
    for (int i = 0; i < 70; i++) cyc(0,0,0,1,0,100+i,0,0,0);
    chk("R7 count held at 64", int'(fill_level), 64);
    chk("R7 overflow set", int'(overflow), 1);
    // full with read and write together: read wins, write dropped
    cyc(1,0,8'hEE,0,1,0,0,0,0);
    chk("R7 full rw count", int'(fill_level), 63);
    chk("R7 full rw data", int'(rd_data), 100);

    // R4/R5 drain with watermark 20
    cyc(0,0,0,0,0,0,0,1,20);
    while (q.size() > 0) cyc(0,0,0,0,1,0,0,0,0);

    // R8 empty reads
    for (int i = 0; i < 3; i++) begin
      cyc(0,0,0,0,1,0,0,0,0);
      chk("R8 empty read data", int'(rd_data), 0);
      chk("R8 empty read count", int'(fill_level), 0);
    end

    // R10 balanced traffic
    for (int i = 0; i < 5; i++) cyc(1,0,i+40,0,0,0,0,0,0);
    for (int i = 0; i < 10; i++) cyc(1,0,i+50,0,1,0,0,0,0);
    chk("R10 count unchanged", int'(fill_level), 5);

    // R9 flush clears
    cyc(0,0,0,0,0,0,1,0,0);
    chk("R9 flush count", int'(fill_level), 0);
    chk("R9 flush ovf", int'(overflow), 0);
    chk("R9 flush keeps wm", int'(wm_level), 20);

    // R11 host priority on write, single pop on dual read
    cyc(1,0,8'hAA,1,0,8'h55,0,0,0);
    chk("R11 one byte stored", int'(fill_level), 1);
    cyc(1,0,8'h11,0,0,0,0,0,0);
    cyc(0,1,0,0,1,0,0,0,0);
    chk("R11 host byte", int'(rd_data), 8'hAA);
    chk("R11 single pop", int'(fill_level), 1);

    // R9 flush wins over concurrent write and read
    cyc(1,1,8'h77,0,0,0,1,0,0);
    chk("R9 flush priority", int'(fill_level), 0);
    chk("R9 rd_data held", int'(rd_data), 8'hAA);

    // watermark extremes
    cyc(0,0,0,0,0,0,0,1,0);
    for (int i = 0; i < 64; i++) cyc(0,0,0,1,0,i,0,0,0);
    cyc(0,0,0,0,0,0,0,1,63);
    chk("R4 high at wm 63", int'(alert_high), 1);
    cyc(0,0,0,0,0,0,1,0,0);

    // random traffic, push-weighted then pop-weighted
    for (int i = 0; i < 6000; i++) begin
      int wbias;
      wbias = (i < 3000) ? 70 : 30;
      cyc(($urandom % 100) < wbias/2, ($urandom % 100) < 20, $urandom % 256,
          ($urandom % 100) < wbias/2, ($urandom % 100) < 20, $urandom % 256,
          ($urandom % 400) == 0, ($urandom % 50) == 0, $urandom % 64);
    end
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule